// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block reads an 8 by 8 grid of switches one row at a time and keeps a 64-bit picture of which switches are closed. It raises one select line at a time, each for three clock cycles, and reads the eight return lines that come back through any closed switches. After the eighth row it raises a ninth output for three cycles to mark a finished pass. The block then starts the next pass at row 0.

The picture is presented as four 16-bit words. Switch number n is 8 times its row plus its return column. It appears at bit n mod 16 of word n div 16. Row samples go into a private shadow store. All four words are replaced together when the ninth output rises, so software never sees a half-scanned pass. A released switch clears its bit on the next full pass. An enable input stops all scanning when low. While it is low the select lines go quiet and the words keep their last values. Raising it again starts a fresh pass at row 0.

Top module: `keymatrix_scanner`

## Requirements
- R1: While `rst_n` is low, all nine bits of `sel_out` are 0 and all four result words are 0.
- R2: A cycle that follows a clock edge sampled with `enable` low has `sel_out` equal to 0 and `result` unchanged from the cycle before.
- R3: With `enable` high, select bits 0 to 7 become active in ascending order, and each stays active for exactly 3 consecutive cycles.
- R4: At most one of the nine `sel_out` bits is high in any cycle.
- R5: Bit 8 of `sel_out` is high for the 3 cycles right after select bit 7, and select bit 0 follows it.
- R6: Switch n = 8*row + column is reported at bit n of the flat 64-bit map. Word k (`result[k]`) holds switches 16k to 16k+15 in bits 0 to 15.
- R7: The return lines for a row are sampled only at the clock edge that ends that row's third dwell cycle. A level present only in the first two dwell cycles is not recorded.
- R8: `result` changes only at the clock edge where bit 8 of `sel_out` rises. At that edge all 64 bits are replaced by the completed pass.
- R9: Every pass records all 64 positions. A switch open for a whole pass reads 0 after that pass, even if it was 1 before.
- R10: When `enable` is sampled high while the block is idle, select bit 0 is active in the following cycle. This applies after reset and after an enable drop in the middle of a pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enable | input | 1 | Scanning runs while high |
| ret_in | input | 8 | Return lines from the matrix columns |
| sel_out | output | 9 | One-hot row selects (bits 0 to 7) and pass-complete flag (bit 8) |
| result | output | 4x16 | Key map words; word k holds switches 16k to 16k+15 |

## Verification
The bench builds the block with its default parameters: 8 rows, 8 return lines, a dwell of 3 and 16-bit words. With these values every switch position and every word boundary is exercised, including bits 15/16 and 47/48. Switch patterns change in the middle of a pass, so the shadow store must hide partial passes. Directed timing moves a return level into and out of the sampling cycle. Enable is dropped in the middle of a pass to test the hold and restart paths.

// File: rtl/kms_pkg.sv
package kms_pkg;
  // default geometry of the scanned grid
  localparam int unsigned KMS_LINES   = 8;
  localparam int unsigned KMS_RETURNS = 8;
  localparam int unsigned KMS_DWELL   = 3;
  localparam int unsigned KMS_WORD_W  = 16;

  // phase of the scan position within a pass
  typedef enum logic [1:0] {
    POS_IDLE = 2'd0,
    POS_ROW  = 2'd1,
    POS_DONE = 2'd2
  } kms_pos_e;
endpackage

// File: rtl/kms_seq.sv
// Scan sequencer: walks rows 0..LINES-1, then the done slot, DWELL cycles each.
module kms_seq
  import kms_pkg::*;
#(
  parameter int unsigned LINES = KMS_LINES,
  parameter int unsigned DWELL = KMS_DWELL,
  localparam int unsigned PH_W = $clog2(LINES + 1),
  localparam int unsigned DW_W = (DWELL > 1) ? $clog2(DWELL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  output logic            active,
  output logic [PH_W-1:0] phase,
  output kms_pos_e        pos,
  output logic            row_strobe,
  output logic            round_end
);
  localparam logic [PH_W-1:0] PH_DONE = PH_W'(LINES);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(LINES - 1);
  localparam logic [DW_W-1:0] DW_LAST = DW_W'(DWELL - 1);

  logic            active_q, active_d;
  logic [PH_W-1:0] phase_q,  phase_d;
  logic [DW_W-1:0] dwell_q,  dwell_d;
  logic            step_en;
  logic            dwell_last;

  assign dwell_last = (dwell_q == DW_LAST);
  assign step_en    = enable | active_q;

  // next state
  always_comb begin
    active_d = active_q;
    phase_d  = phase_q;
    dwell_d  = dwell_q;
    if (!enable) begin
      // R2, R10: stop and rewind to row 0
      active_d = 1'b0;
      phase_d  = '0;
      dwell_d  = '0;
    end else if (!active_q) begin
      active_d = 1'b1;
      phase_d  = '0;
      dwell_d  = '0;
    end else if (dwell_last) begin
      dwell_d = '0;
      phase_d = (phase_q == PH_DONE) ? '0 : phase_q + 1'b1;
    end else begin
      dwell_d = dwell_q + 1'b1;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= '0;
      dwell_q  <= '0;
    end else if (step_en) begin
      active_q <= active_d;
      phase_q  <= phase_d;
      dwell_q  <= dwell_d;
    end
  end

  always_comb begin
    if (!active_q)                pos = POS_IDLE;
    else if (phase_q == PH_DONE)  pos = POS_DONE;
    else                          pos = POS_ROW;
  end

  assign active     = active_q;
  assign phase      = phase_q;
  // R7: sample on the edge closing the last dwell cycle of a row
  assign row_strobe = enable && (pos == POS_ROW) && dwell_last;
  assign round_end  = row_strobe && (phase_q == PH_LAST);
endmodule

// File: rtl/kms_select.sv
// Decodes the scan position into one-hot select lines plus the done flag.
module kms_select #(
  parameter int unsigned LINES = 8,
  localparam int unsigned PH_W = $clog2(LINES + 1)
) (
  input  logic            active,
  input  logic [PH_W-1:0] phase,
  output logic [LINES:0]  sel
);
  for (genvar i = 0; i <= LINES; i++) begin : g_sel
    assign sel[i] = active && (phase == PH_W'(i));
  end
endmodule

// File: rtl/kms_capture.sv
// Row shadow store and the committed key map.
module kms_capture #(
  parameter int unsigned LINES   = 8,
  parameter int unsigned RETURNS = 8,
  parameter int unsigned WORD_W  = 16,
  localparam int unsigned PH_W   = $clog2(LINES + 1),
  localparam int unsigned NKEYS  = LINES * RETURNS,
  localparam int unsigned NWORDS = NKEYS / WORD_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           row_strobe,
  input  logic                           round_end,
  input  logic [PH_W-1:0]                phase,
  input  logic [RETURNS-1:0]             ret_in,
  output logic [NWORDS-1:0][WORD_W-1:0]  result
);
  logic [NKEYS-1:0] commit_map;
  logic [NKEYS-1:0] map_q;

  for (genvar r = 0; r < LINES; r++) begin : g_row
    if (r < LINES - 1) begin : g_shadow
      logic             row_we;
      logic [RETURNS-1:0] row_q;
      assign row_we = row_strobe && (phase == PH_W'(r));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      row_q <= '0;
        else if (row_we) row_q <= ret_in;
      end
      // R6: key index = row*RETURNS + column
      assign commit_map[r*RETURNS +: RETURNS] = row_q;
    end else begin : g_direct
      // last row goes straight into the commit
      assign commit_map[r*RETURNS +: RETURNS] = ret_in;
    end
  end

  // R8, R9: all positions replaced together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         map_q <= '0;
    else if (round_end) map_q <= commit_map;
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign result[w] = map_q[w*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/keymatrix_scanner.sv
module keymatrix_scanner
  import kms_pkg::*;
#(
  parameter int unsigned LINES   = KMS_LINES,
  parameter int unsigned RETURNS = KMS_RETURNS,
  parameter int unsigned DWELL   = KMS_DWELL,
  parameter int unsigned WORD_W  = KMS_WORD_W,
  localparam int unsigned PH_W   = $clog2(LINES + 1),
  localparam int unsigned NWORDS = (LINES * RETURNS) / WORD_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          enable,
  input  logic [RETURNS-1:0]            ret_in,
  output logic [LINES:0]                sel_out,
  output logic [NWORDS-1:0][WORD_W-1:0] result
);
  logic            active;
  logic [PH_W-1:0] phase;
  kms_pos_e        pos;
  logic            row_strobe;
  logic            round_end;

  kms_seq #(.LINES(LINES), .DWELL(DWELL)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .active     (active),
    .phase      (phase),
    .pos        (pos),
    .row_strobe (row_strobe),
    .round_end  (round_end)
  );

  kms_select #(.LINES(LINES)) u_sel (
    .active (active),
    .phase  (phase),
    .sel    (sel_out)
  );

  kms_capture #(.LINES(LINES), .RETURNS(RETURNS), .WORD_W(WORD_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .row_strobe (row_strobe),
    .round_end  (round_end),
    .phase      (phase),
    .ret_in     (ret_in),
    .result     (result)
  );
endmodule

// File: rtl/kms_chk.sv
module kms_chk #(
  parameter int unsigned LINES  = 8,
  parameter int unsigned DWELL  = 3,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned NWORDS = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          enable,
  input logic [LINES:0]                sel_out,
  input logic [NWORDS-1:0][WORD_W-1:0] result
);
  logic [LINES:0] prev_sel;
  logic [7:0]     run_len;
  logic           step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sel <= '0;
      run_len  <= 8'd0;
    end else begin
      prev_sel <= sel_out;
      if (sel_out != prev_sel) run_len <= 8'd1;
      else if (run_len != 8'hFF) run_len <= run_len + 8'd1;
    end
  end

  // a move from one active line directly to another
  assign step = (sel_out != '0) && (prev_sel != '0) && (sel_out != prev_sel);

  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_out));

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (sel_out == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(result));

  p_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $rose(sel_out[LINES]));

  p_dwell_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (run_len == 8'(DWELL)));

  p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (sel_out == {prev_sel[LINES-1:0], prev_sel[LINES]}));

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sel_out == '0) |=> (sel_out == (LINES+1)'(1)));
endmodule

bind keymatrix_scanner kms_chk #(
  .LINES(LINES), .DWELL(DWELL), .WORD_W(WORD_W), .NWORDS(NWORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sel_out(sel_out), .result(result)
);

// File: tb/keymatrix_scanner_test.sv
module keymatrix_scanner_test;
  localparam int LINES = 8, RETURNS = 8, DWELL = 3, WORD_W = 16;
  localparam int NK = LINES * RETURNS, NW = NK / WORD_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [RETURNS-1:0] ret_in;
  logic [LINES:0] sel_out;
  logic [NW-1:0][WORD_W-1:0] result;
  logic [NK-1:0] pressed = '0;

  int total = 0, bad = 0, cycles = 0;
  bit live = 0;

  // reference model state
  int m_act = 0, m_ph = 0, m_dw = 0;
  logic [NK-1:0] m_shadow = '0, m_res = '0;

  always #5 clk = ~clk;

  keymatrix_scanner uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .ret_in(ret_in), .sel_out(sel_out), .result(result)
  );

  // switch matrix: a closed switch couples its row select to its column
  always_comb begin
    ret_in = '0;
    for (int c = 0; c < RETURNS; c++)
      for (int r = 0; r < LINES; r++)
        if (sel_out[r] && pressed[r*RETURNS + c]) ret_in[c] = 1'b1;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_ph = 0; m_dw = 0; m_shadow = '0; m_res = '0;
    end else if (!enable) begin
      m_act = 0; m_ph = 0; m_dw = 0;
    end else if (m_act == 0) begin
      m_act = 1; m_ph = 0; m_dw = 0;
    end else begin
      if (m_ph < LINES && m_dw == DWELL - 1) begin
        for (int c = 0; c < RETURNS; c++)
          m_shadow[m_ph*RETURNS + c] = pressed[m_ph*RETURNS + c];
        if (m_ph == LINES - 1) m_res = m_shadow;
      end
      m_dw++;
      if (m_dw == DWELL) begin
        m_dw = 0;
        m_ph = (m_ph + 1) % (LINES + 1);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    cycles++;
    if (live) begin
      logic [LINES:0] es;
      es = (m_act != 0) ? ((LINES+1)'(1) << m_ph) : '0;
      chk(sel_out == es, (m_ph == LINES) ? "R5" : "R3", "select lines",
          64'(sel_out), 64'(es));
      chk(result == m_res, "R8", "result map", 64'(result), 64'(m_res));
    end
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (sel_out[LINES]);
    do @(negedge clk); while (!sel_out[LINES]);
  endtask

  initial begin
    logic [NK-1:0] pa, pb;
    pa = 64'h8001_0000_ABCD_8001;
    pb = 64'h0000_FFFF_0000_0181;
    repeat (3) @(negedge clk);
    chk(sel_out == '0, "R1", "reset selects", 64'(sel_out), 64'd0);
    chk(result == '0, "R1", "reset map", 64'(result), 64'd0);
    rst_n = 1'b1;
    live = 1;
    repeat (5) @(negedge clk);
    chk(sel_out == '0, "R2", "idle selects", 64'(sel_out), 64'd0);

    enable = 1'b1;
    @(negedge clk);
    chk(sel_out == 9'd1, "R10", "first row", 64'(sel_out), 64'd1);
    pressed = pa;
    wait_done(); wait_done();
    chk(result == pa, "R6", "full map", 64'(result), pa);
    chk(result[1] == pa[31:16], "R6", "word 1", 64'(result[1]), 64'(pa[31:16]));
    chk(result[3] == pa[63:48], "R6", "word 3", 64'(result[3]), 64'(pa[63:48]));

    pressed = pb;
    wait_done(); wait_done();
    chk(result == pb, "R9", "released keys", 64'(result), pb);

    // R7: level only in early dwell cycles of row 2 is missed
    pressed = '0;
    do @(negedge clk); while (!sel_out[2]);
    pressed[18] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    pressed[18] = 1'b0; pressed[19] = 1'b1;
    @(negedge clk);
    pressed[19] = 1'b0;
    do @(negedge clk); while (!sel_out[LINES]);
    chk(result[1][2] == 1'b0, "R7", "early level key 18", 64'(result[1][2]), 64'd0);
    chk(result[1][3] == 1'b1, "R7", "sampled key 19", 64'(result[1][3]), 64'd1);

    // R2 hold and R10 restart
    pressed = pb;
    wait_done(); wait_done();
    do @(negedge clk); while (!sel_out[3]);
    enable = 1'b0;
    pressed = ~pb;
    repeat (10) begin
      @(negedge clk);
      chk(result == pb, "R2", "held map", 64'(result), pb);
      chk(sel_out == '0, "R2", "quiet selects", 64'(sel_out), 64'd0);
    end
    enable = 1'b1;
    @(negedge clk);
    chk(sel_out == 9'd1, "R10", "restart row", 64'(sel_out), 64'd1);
    wait_done();
    chk(result == ~pb, "R9", "fresh pass map", 64'(result), ~pb);

    // random traffic, model compares every cycle
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (($urandom % 5) == 0) pressed = {$urandom, $urandom};
      enable = (($urandom % 20) != 0);
    end
    enable = 1'b1;
    repeat (5) @(negedge clk);
    live = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule